// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block takes one fast source clock and derives from it three banks of clock-like outputs (A, B and C, four outputs each) and a single feedback output. Each of these four paths has its own integer divider. A prescale select chooses whether the dividers advance on every source edge or on every second one. The ratio of each bank is picked by a 2-bit select, and the feedback ratio by a 3-bit select. The ratio tables differ between banks, and the feedback table repeats one ratio.

An active-low master reset is sampled on the source clock. It clears every divider, forces all outputs low and drops an output-enable flag. The flag stands in for the high-impedance state of a physical driver. A control input inverts the upper two outputs of bank C. All dividers leave reset on the same source edge, so their rising edges line up. A ratio change waits for the end of the current output period, so no short pulse is produced.

Top module: `clkdiv_banks`

## Requirements
- R1: Dividers advance one count ("tick") per source edge when `pre_sel` is 1. When `pre_sel` is 0 they advance only on the 2nd, 4th, 6th, ... source edge after reset release, which halves the rate.
- R2: Bank A select values 0, 1, 2, 3 give divide ratios of 4, 6, 8, 12 ticks.
- R3: Bank B select values 0, 1, 2, 3 give divide ratios of 4, 6, 8, 10 ticks.
- R4: Bank C select values 0, 1, 2, 3 give divide ratios of 2, 4, 6, 8 ticks.
- R5: Feedback select values 0 to 7 give divide ratios of 4, 6, 8, 10, 8, 12, 16, 20 ticks.
- R6: Let T be the number of ticks since reset release and N the ratio. Each non-inverted output then equals floor(T/(N/2)) mod 2. Every output therefore starts low, has a 50% duty cycle, and rises in step with the other outputs.
- R7: When `inv_c` is 1, bank C bits 3 and 2 show the complement of the bank C divider. When `inv_c` is 0 they are not inverted. Bits 1 and 0 are never inverted.
- R8: A source edge that samples `rst_n` low drives every output and `out_en` to 0, whatever `inv_c` is, and clears all divider state. `out_en` is 1 after every edge that samples `rst_n` high.
- R9: A ratio-select change made while running takes effect only at the next falling edge of that divider's output, that is at the end of a whole period. Other dividers are unaffected.
- R10: The outputs within one bank come from one shared divider. Apart from inversion under R7, they are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| pre_sel | input | 1 | 1: tick every edge, 0: every second edge |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_c | input | 1 | Invert bank C bits 3 and 2 |
| bank_a | output | 4 | Bank A outputs |
| bank_b | output | 4 | Bank B outputs |
| bank_c | output | 4 | Bank C outputs |
| fb_out | output | 1 | Feedback output |
| out_en | output | 1 | Output-enable flag, low in reset |

## Verification
The hardest situation to reach is a ratio change in the middle of a period. The divider must finish the old period and switch only at its falling edge, and that edge falls at a different time for every ratio and prescale mode. The stimulus changes the bank A and feedback selects at chosen edges while the dividers run, in both prescale modes. The expected switch point is worked out as the next multiple of the old period after the tick count at the moment of the change. Outside these tests, every combination of prescale, bank ratio and feedback ratio is swept from reset, with the inversion control alternating between runs.

// File: rtl/clkdiv_pkg.sv
// Shared types and ratio decoding for the multi-bank clock divider.
// Assumes every ratio is even, so that each one is stored as a half period.
package clkdiv_pkg;

    typedef enum logic [1:0] {
        DIV_BANK_A,
        DIV_BANK_B,
        DIV_BANK_C,
        DIV_FEEDBACK
    } div_kind_e;

    // Half-period length in ticks for a given divider kind and select value.
    function automatic int half_of(div_kind_e kind, logic [2:0] s);
        int lo;
        lo = int'(s[1:0]);
        case (kind)
            DIV_BANK_A:   half_of = (lo == 3) ? 6 : lo + 2;
            DIV_BANK_B:   half_of = lo + 2;
            DIV_BANK_C:   half_of = lo + 1;
            default:      half_of = s[2] ? ((lo == 0) ? 4 : 2 * (lo + 2)) : lo + 2;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_prescale.sv
// Prescaler: produces a tick enable, either on every source edge or on
// every second one. Assumes a synchronous active-low reset on clk.
module clkdiv_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_sel,
    output logic tick
);
    logic ph_q;

    // Phase toggle that marks alternate edges for the halved mode.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    assign tick = pre_sel | ph_q;
endmodule

// File: rtl/clkdiv_counter.sv
// Even-ratio divider with a 50% duty cycle. The ratio table is picked by KIND.
// A new select value is taken in only when the output falls (end of period).
// Assumes CNT_W bits hold the largest half period.
module clkdiv_counter #(
    parameter clkdiv_pkg::div_kind_e KIND = clkdiv_pkg::DIV_BANK_A,
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] sel,
    output logic       div_out
);
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q;
    logic             term;

    assign term = (cnt_q == half_q - 1'b1);

    // Count ticks, toggle at each half period, reload the ratio at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            out_q  <= 1'b0;
            half_q <= CNT_W'(clkdiv_pkg::half_of(KIND, sel));
        end else if (tick) begin
            if (term) begin
                cnt_q <= '0;
                out_q <= ~out_q;
                if (out_q) half_q <= CNT_W'(clkdiv_pkg::half_of(KIND, sel));
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign div_out = out_q;
endmodule

// File: rtl/clkdiv_fanout.sv
// Drives NUM_OUT copies of one divided clock. The copies flagged in INV_MASK
// are inverted under inv, and every copy is held low while en is low.
module clkdiv_fanout #(
    parameter int NUM_OUT = 4,
    parameter logic [NUM_OUT-1:0] INV_MASK = '0
) (
    input  logic               raw,
    input  logic               en,
    input  logic               inv,
    output logic [NUM_OUT-1:0] q
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        if (INV_MASK[g]) begin : g_inv
            assign q[g] = en & (raw ^ inv);
        end else begin : g_pass
            assign q[g] = en & raw;
        end
    end
endmodule

// File: rtl/clkdiv_banks.sv
// Top level: three output banks and one feedback output, each from its own
// divider, all fed by a shared prescale tick. Reset is synchronous and
// active low on clk_src. The enable flag models the driver state.
module clkdiv_banks #(
    parameter int NUM_OUT = 4,
    parameter int CNT_W   = 4,
    parameter logic [NUM_OUT-1:0] C_INV_MASK = 4'b1100
) (
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic               pre_sel,
    input  logic [1:0]         sel_a,
    input  logic [1:0]         sel_b,
    input  logic [1:0]         sel_c,
    input  logic [2:0]         sel_fb,
    input  logic               inv_c,
    output logic [NUM_OUT-1:0] bank_a,
    output logic [NUM_OUT-1:0] bank_b,
    output logic [NUM_OUT-1:0] bank_c,
    output logic               fb_out,
    output logic               out_en
);
    import clkdiv_pkg::*;

    logic tick;
    logic raw_a, raw_b, raw_c, raw_fb;
    logic en_q;

    // Output enable follows the sampled reset.
    always_ff @(posedge clk_src) begin
        en_q <= rst_n;
    end
    assign out_en = en_q;

    clkdiv_prescale u_pre (
        .clk(clk_src), .rst_n(rst_n), .pre_sel(pre_sel), .tick(tick)
    );

    clkdiv_counter #(.KIND(DIV_BANK_A), .CNT_W(CNT_W)) u_div_a (
        .clk(clk_src), .rst_n(rst_n), .tick(tick), .sel({1'b0, sel_a}), .div_out(raw_a)
    );
    clkdiv_counter #(.KIND(DIV_BANK_B), .CNT_W(CNT_W)) u_div_b (
        .clk(clk_src), .rst_n(rst_n), .tick(tick), .sel({1'b0, sel_b}), .div_out(raw_b)
    );
    clkdiv_counter #(.KIND(DIV_BANK_C), .CNT_W(CNT_W)) u_div_c (
        .clk(clk_src), .rst_n(rst_n), .tick(tick), .sel({1'b0, sel_c}), .div_out(raw_c)
    );
    clkdiv_counter #(.KIND(DIV_FEEDBACK), .CNT_W(CNT_W)) u_div_fb (
        .clk(clk_src), .rst_n(rst_n), .tick(tick), .sel(sel_fb), .div_out(raw_fb)
    );

    clkdiv_fanout #(.NUM_OUT(NUM_OUT), .INV_MASK('0)) u_fan_a (
        .raw(raw_a), .en(en_q), .inv(inv_c), .q(bank_a)
    );
    clkdiv_fanout #(.NUM_OUT(NUM_OUT), .INV_MASK('0)) u_fan_b (
        .raw(raw_b), .en(en_q), .inv(inv_c), .q(bank_b)
    );
    clkdiv_fanout #(.NUM_OUT(NUM_OUT), .INV_MASK(C_INV_MASK)) u_fan_c (
        .raw(raw_c), .en(en_q), .inv(inv_c), .q(bank_c)
    );
    clkdiv_fanout #(.NUM_OUT(1), .INV_MASK(1'b0)) u_fan_fb (
        .raw(raw_fb), .en(en_q), .inv(inv_c), .q(fb_out)
    );
endmodule

// File: rtl/clkdiv_banks_chk.sv
// Property checker for clkdiv_banks, attached by bind. Assumes the default
// 4-output banks with the inversion mask on bank C bits 3 and 2.
module clkdiv_banks_chk (
    input logic       clk_src,
    input logic       rst_n,
    input logic       inv_c,
    input logic [3:0] bank_a,
    input logic [3:0] bank_b,
    input logic [3:0] bank_c,
    input logic       out_en
);
    // R8: an edge that samples reset low leaves every output idle.
    p_reset_idle_r8: assert property (@(posedge clk_src)
        !rst_n |=> (bank_a == 4'h0 && bank_b == 4'h0 && bank_c == 4'h0 && !out_en));

    // R10: bank A copies always agree.
    p_bank_a_same_r10: assert property (@(posedge clk_src) disable iff (!rst_n)
        out_en |-> (bank_a == 4'h0 || bank_a == 4'hF));

    // R10: bank B copies always agree.
    p_bank_b_same_r10: assert property (@(posedge clk_src) disable iff (!rst_n)
        out_en |-> (bank_b == 4'h0 || bank_b == 4'hF));

    // R7: the lower bank C bits are never inverted and stay equal.
    p_c_low_plain_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
        out_en |-> (bank_c[0] == bank_c[1]));

    // R7: the upper bank C bits follow the lower ones, flipped under inv_c.
    p_c_high_inv_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
        out_en |-> (bank_c[3] == bank_c[2] && bank_c[2] == (bank_c[0] ^ inv_c)));
endmodule

bind clkdiv_banks clkdiv_banks_chk u_chk (
    .clk_src(clk_src), .rst_n(rst_n), .inv_c(inv_c),
    .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c), .out_en(out_en)
);

// File: tb/test_clkdiv_banks.sv
// Self-checking bench: sweeps every prescale/ratio combination from reset,
// then changes ratios while running. Expected values come from tick arithmetic.
module test_clkdiv_banks;
    logic       clk_src = 1'b0;
    logic       rst_n   = 1'b0;
    logic       pre_sel = 1'b1;
    logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
    logic [2:0] sel_fb = '0;
    logic       inv_c = 1'b0;
    logic [3:0] bank_a, bank_b, bank_c;
    logic       fb_out, out_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk_src = ~clk_src;

    clkdiv_banks i_clkdiv_banks (
        .clk_src(clk_src), .rst_n(rst_n), .pre_sel(pre_sel),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c(inv_c), .bank_a(bank_a), .bank_b(bank_b), .bank_c(bank_c),
        .fb_out(fb_out), .out_en(out_en)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk_src) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Half periods taken from the requirement tables (ratio / 2).
    function automatic int h_a(int s);  int t[4] = '{2, 3, 4, 6};  return t[s]; endfunction
    function automatic int h_b(int s);  int t[4] = '{2, 3, 4, 5};  return t[s]; endfunction
    function automatic int h_c(int s);  int t[4] = '{1, 2, 3, 4};  return t[s]; endfunction
    function automatic int h_fb(int s); int t[8] = '{2, 3, 4, 5, 4, 6, 8, 10}; return t[s]; endfunction

    // R1: ticks seen after source edge j since release.
    function automatic int ticks(int j, bit pre);
        return pre ? j : j / 2;
    endfunction

    // R6: ideal output level after T ticks with half period h.
    function automatic int lvl(int t, int h);
        return (t / h) % 2;
    endfunction

    function automatic int rep4(int b);
        return b ? 4'hF : 4'h0;
    endfunction

    function automatic int cvec(int b, bit inv);
        int hi;
        hi = b ^ int'(inv);
        return (hi ? 4'hC : 4'h0) | (b ? 4'h3 : 4'h0);
    endfunction

    // Reset, set up the configuration, check the idle state, then release.
    task automatic start_run(input bit pre, input int sa, input int sb, input int sc,
                             input int sf, input bit inv);
        @(negedge clk_src);
        rst_n = 1'b0; pre_sel = pre; inv_c = 1'b1;
        sel_a = 2'(sa); sel_b = 2'(sb); sel_c = 2'(sc); sel_fb = 3'(sf);
        @(negedge clk_src);
        @(negedge clk_src);
        chk("R8 reset bank_a", int'(bank_a), 0);
        chk("R8 reset bank_c with invert set", int'(bank_c), 0);
        chk("R8 reset fb_out", int'(fb_out), 0);
        chk("R8 reset out_en", int'(out_en), 0);
        inv_c = inv;
        rst_n = 1'b1;
    endtask

    // Bound for R9: first end of an old period strictly after tick count tc.
    function automatic int bnd(int tc, int h0);
        return (tc / (2 * h0) + 1) * (2 * h0);
    endfunction

    // R9: run, change bank A and feedback ratios after edge jc, check the switch.
    task automatic change_run(input bit pre, input int a0, input int a1,
                              input int f0, input int f1, input int jc);
        int ba, bf, t;
        start_run(pre, a0, 2, 1, f0, 1'b0);
        ba = 0; bf = 0;
        for (int j = 1; j <= 140; j++) begin
            @(negedge clk_src);
            t = ticks(j, pre);
            if (j <= jc || t < ba) chk("R9 bank_a before switch", int'(bank_a), rep4(lvl(t, h_a(a0))));
            else                   chk("R9 bank_a after switch",  int'(bank_a), rep4(lvl(t - ba, h_a(a1))));
            if (j <= jc || t < bf) chk("R9 fb before switch", int'(fb_out), lvl(t, h_fb(f0)));
            else                   chk("R9 fb after switch",  int'(fb_out), lvl(t - bf, h_fb(f1)));
            chk("R9 bank_b unaffected", int'(bank_b), rep4(lvl(t, h_b(2))));
            if (j == jc) begin
                ba = bnd(t, h_a(a0));
                bf = bnd(t, h_fb(f0));
                sel_a = 2'(a1);
                sel_fb = 3'(f1);
            end
        end
    endtask

    initial begin
        int t;
        repeat (2) @(negedge clk_src);
        // R2 R3 R4 R5 R6 R7 R10: exhaustive sweep from reset.
        for (int p = 0; p < 2; p++) begin
            for (int f = 0; f < 8; f++) begin
                for (int i = 0; i < 4; i++) begin
                    bit inv;
                    inv = bit'((f + i) % 2);
                    start_run(bit'(p), i, (i + 1) % 4, (i + 2) % 4, f, inv);
                    for (int j = 1; j <= 90; j++) begin
                        @(negedge clk_src);
                        t = ticks(j, bit'(p));
                        chk("R8 out_en after release", int'(out_en), 1);
                        chk("R2 R6 R10 bank_a", int'(bank_a), rep4(lvl(t, h_a(i))));
                        chk("R3 R6 R10 bank_b", int'(bank_b), rep4(lvl(t, h_b((i + 1) % 4))));
                        chk("R4 R7 bank_c", int'(bank_c), cvec(lvl(t, h_c((i + 2) % 4)), inv));
                        chk("R1 R5 fb_out", int'(fb_out), lvl(t, h_fb(f)));
                    end
                end
            end
        end
        // R7: flip inv_c while running; only bits 3 and 2 follow it.
        start_run(1'b1, 0, 0, 3, 0, 1'b0);
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk_src);
            chk("R7 bank_c live invert", int'(bank_c), cvec(lvl(j, 4), inv_c));
            inv_c = ~inv_c;
        end
        // R9: mid-period ratio changes in both prescale modes.
        change_run(1'b1, 0, 3, 0, 7, 5);
        change_run(1'b1, 3, 0, 6, 1, 13);
        change_run(1'b0, 1, 0, 5, 2, 9);
        change_run(1'b0, 2, 3, 3, 4, 16);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule